// File: doc/BRIEF.md
# Indirect Bank Configuration Port

This block is the configuration register file of an external-bus controller, reached over a device-control-register bus through two bus registers. One is an index port that holds a 32-bit pointer. The other is a data window that returns the internal register the pointer selects. Software loads the pointer with one bus write and then fetches the chosen register with a read of the window.

The block holds eight bank configuration registers, eight bank access-parameter registers, an error-address register, two error-status registers and a global configuration register. Writes through the data window are accepted and acknowledged, but they change nothing. The internal registers therefore keep their reset values, and only the pointer can be changed by software.

Bus handshake: a small state machine with two states, `ST_IDLE` and `ST_ACK`. In `ST_IDLE` a strobe is accepted, which is the transition `T_ACCEPT` to `ST_ACK`. The access is decoded on that edge and the read result is registered. `ST_ACK` drives the acknowledge for exactly one cycle, then returns unconditionally to `ST_IDLE` (transition `T_DONE`). A strobe seen while in `ST_ACK` is not sampled, so requesters pulse the strobe for one cycle and wait for the acknowledge.

Top module: `ebc_cfg_port`

## Requirements
- R1: After reset the pointer is zero, `ack_o` is low and `rdata_o` is zero.
- R2: A strobe accepted in the idle state raises `ack_o` on the next cycle, for exactly one cycle. Reads and writes behave the same way.
- R3: A write to bus register 0x012 stores all 32 bits of `wdata_i` in the pointer. A read of 0x012 returns the stored value.
- R4: A read of the data window (bus register 0x013) with pointer values 0x00 to 0x07 returns bank configuration register 0 to 7. All of these are zero.
- R5: Pointer values 0x10 to 0x17 select bank access-parameter registers 0 to 7. All of these read as zero.
- R6: Pointer 0x20 selects the error-address register, which reads zero. Pointers 0x21 and 0x22 select the two error-status registers, which also read zero.
- R7: Pointer 0x23 selects the global configuration register, which reads 0x80400000.
- R8: A data-window read with any other pointer value returns zero. This includes a pointer whose upper 24 bits are not zero, such as 0x00000123.
- R9: A write to the data window changes no register. A later read of 0x023 through the window still returns 0x80400000, and the pointer is unchanged.
- R10: A read of any bus register number other than 0x012 and 0x013 returns zero. A write to such a number leaves the pointer unchanged.
- R11: `rdata_o` is zero whenever `ack_o` is low, and on the acknowledge of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| regnum_i | input | 10 | Bus register number |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access acknowledge, one cycle |
| rdata_o | output | 32 | Read data, valid with `ack_o` |

## Verification
The bench builds the block with its default parameters: eight banks, a 10-bit register number, and the index and data ports at 0x012 and 0x013. With these values the edges of both bank ranges (0x07/0x08 and 0x17/0x18) can be reached, as can the last defined index 0x23 and its neighbour 0x24. So can pointers that match a defined index only in their low byte. Random accesses mix pointer loads, window reads and writes, and accesses to unmapped register numbers. Every result is compared with a bench model of the index map.

// File: rtl/ebc_cfg_pkg.sv
package ebc_cfg_pkg;
    parameter int unsigned DW = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1
    } hs_state_t;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_BCFG  = 3'd1,
        SEL_BPAR  = 3'd2,
        SEL_EADDR = 3'd3,
        SEL_ESTA0 = 3'd4,
        SEL_ESTA1 = 3'd5,
        SEL_GCFG  = 3'd6
    } sel_kind_t;

    parameter logic [DW-1:0] GCFG_RST = 32'h8040_0000;
endpackage

// File: rtl/ebc_idx_decode.sv
module ebc_idx_decode
    import ebc_cfg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    parameter logic [DW-1:0] BCFG_BASE = 32'h00,
    parameter logic [DW-1:0] BPAR_BASE = 32'h10,
    parameter logic [DW-1:0] MISC_BASE = 32'h20,
    localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [DW-1:0] idx_i,
    output sel_kind_t     kind_o,
    output logic [BW-1:0] bank_o
);
    localparam logic [DW-1:0] NB = DW'(NUM_BANKS);

    logic [DW-1:0] off_cfg, off_par, off_misc;

    always_comb begin
        off_cfg  = idx_i - BCFG_BASE;
        off_par  = idx_i - BPAR_BASE;
        off_misc = idx_i - MISC_BASE;
        kind_o   = SEL_NONE;
        bank_o   = '0;
        if (idx_i >= BCFG_BASE && off_cfg < NB) begin
            kind_o = SEL_BCFG;
            bank_o = off_cfg[BW-1:0];
        end else if (idx_i >= BPAR_BASE && off_par < NB) begin
            kind_o = SEL_BPAR;
            bank_o = off_par[BW-1:0];
        end else if (idx_i >= MISC_BASE) begin
            unique case (off_misc)
                32'd0:   kind_o = SEL_EADDR;
                32'd1:   kind_o = SEL_ESTA0;
                32'd2:   kind_o = SEL_ESTA1;
                32'd3:   kind_o = SEL_GCFG;
                default: kind_o = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ebc_cfg_store.sv
module ebc_cfg_store
    import ebc_cfg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sel_kind_t     kind_i,
    input  logic [BW-1:0] bank_i,
    output logic [DW-1:0] data_o
);
    logic [DW-1:0] bcfg_q [NUM_BANKS];
    logic [DW-1:0] bpar_q [NUM_BANKS];
    logic [DW-1:0] eaddr_q, esta0_q, esta1_q, gcfg_q;

    // Registers have no software write path; only reset sets them.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bcfg_q[b] <= '0;
                bpar_q[b] <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eaddr_q <= '0;
            esta0_q <= '0;
            esta1_q <= '0;
            gcfg_q  <= GCFG_RST;
        end
    end

    always_comb begin
        unique case (kind_i)
            SEL_BCFG:  data_o = bcfg_q[bank_i];
            SEL_BPAR:  data_o = bpar_q[bank_i];
            SEL_EADDR: data_o = eaddr_q;
            SEL_ESTA0: data_o = esta0_q;
            SEL_ESTA1: data_o = esta1_q;
            SEL_GCFG:  data_o = gcfg_q;
            default:   data_o = '0;
        endcase
    end
endmodule

// File: rtl/ebc_cfg_port.sv
module ebc_cfg_port
    import ebc_cfg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned RNW       = 10,
    parameter logic [RNW-1:0] IDX_PORT  = 10'h012,
    parameter logic [RNW-1:0] DATA_PORT = 10'h013,
    localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_i,
    input  logic           we_i,
    input  logic [RNW-1:0] regnum_i,
    input  logic [31:0]    wdata_i,
    output logic           ack_o,
    output logic [31:0]    rdata_o
);
    hs_state_t     state_q, state_d;
    logic [DW-1:0] idx_q;
    logic [DW-1:0] sel_data;
    sel_kind_t     kind;
    logic [BW-1:0] bank;
    logic          accept;

    ebc_idx_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .idx_i  (idx_q),
        .kind_o (kind),
        .bank_o (bank)
    );

    ebc_cfg_store #(.NUM_BANKS(NUM_BANKS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind_i (kind),
        .bank_i (bank),
        .data_o (sel_data)
    );

    assign accept = (state_q == ST_IDLE) && req_i;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_i ? ST_ACK : ST_IDLE;  // T_ACCEPT
            ST_ACK:  state_d = ST_IDLE;                   // T_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and pointer register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            rdata_o <= '0;
        end else if (accept) begin
            rdata_o <= '0;
            if (we_i) begin
                if (regnum_i == IDX_PORT) idx_q <= wdata_i;
            end else if (regnum_i == IDX_PORT) begin
                rdata_o <= idx_q;
            end else if (regnum_i == DATA_PORT) begin
                rdata_o <= sel_data;
            end
        end else begin
            rdata_o <= '0;
        end
    end

    assign ack_o = (state_q == ST_ACK);
endmodule

// File: rtl/ebc_cfg_port_chk.sv
module ebc_cfg_port_chk #(
    parameter int unsigned RNW = 10,
    parameter logic [RNW-1:0] IDX_PORT  = 10'h012,
    parameter logic [RNW-1:0] DATA_PORT = 10'h013
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_i,
    input logic           we_i,
    input logic [RNW-1:0] regnum_i,
    input logic           ack_o,
    input logic [31:0]    rdata_o
);
    p_ack_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !ack_o) |=> ack_o);

    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> (rdata_o == 32'h0));

    p_write_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !ack_o && we_i) |=> (rdata_o == 32'h0));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !ack_o && regnum_i != IDX_PORT && regnum_i != DATA_PORT)
        |=> (rdata_o == 32'h0));
endmodule

bind ebc_cfg_port ebc_cfg_port_chk #(
    .RNW(RNW), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i),
    .regnum_i(regnum_i), .ack_o(ack_o), .rdata_o(rdata_o)
);

// File: tb/ebc_cfg_port_tb.sv
module ebc_cfg_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [9:0]  regnum_i = '0;
    logic [31:0] wdata_i = '0;
    logic        ack_o;
    logic [31:0] rdata_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model_idx = '0;
    logic [31:0] rd;
    logic        ack_seen;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    ebc_cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i),
        .regnum_i(regnum_i), .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o)
    );

    function automatic logic [31:0] exp_window(input logic [31:0] idx);
        return (idx == 32'h23) ? 32'h8040_0000 : 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Strobe set before a rising edge; ack and data sampled at the next falling edge.
    task automatic access(input logic w, input logic [9:0] num, input logic [31:0] d);
        @(negedge clk);
        req_i = 1'b1; we_i = w; regnum_i = num; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0;
        ack_seen = ack_o;
        rd = rdata_o;
        @(negedge clk);
        check("R2 ack drops", {31'b0, ack_o}, 32'h0);
    endtask

    task automatic read_win(input string req, input logic [31:0] exp);
        access(1'b0, 10'h013, 32'h0);
        check(req, rd, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ack", {31'b0, ack_o}, 32'h0);
        check("R1 rdata", rdata_o, 32'h0);
        rst_n = 1'b1;
        access(1'b0, 10'h012, 32'h0);
        check("R1 index", rd, 32'h0);
        check("R2 ack", {31'b0, ack_seen}, 32'h1);

        access(1'b1, 10'h012, 32'hDEAD_BEEF);
        check("R11 write data", rd, 32'h0);
        check("R2 write ack", {31'b0, ack_seen}, 32'h1);
        access(1'b0, 10'h012, 32'h0);
        check("R3", rd, 32'hDEAD_BEEF);

        for (int i = 0; i < 8; i++) begin
            access(1'b1, 10'h012, i);
            read_win("R4", 32'h0);
            access(1'b1, 10'h012, 32'h10 + i);
            read_win("R5", 32'h0);
        end
        for (int i = 0; i < 3; i++) begin
            access(1'b1, 10'h012, 32'h20 + i);
            read_win("R6", 32'h0);
        end
        access(1'b1, 10'h012, 32'h23);
        read_win("R7", 32'h8040_0000);
        access(1'b1, 10'h012, 32'h0000_0123);
        read_win("R8 upper bits", 32'h0);
        access(1'b1, 10'h012, 32'h24);
        read_win("R8 past end", 32'h0);
        access(1'b1, 10'h012, 32'h08);
        read_win("R8 gap", 32'h0);

        access(1'b1, 10'h012, 32'h23);
        access(1'b1, 10'h013, 32'h0000_0000);
        access(1'b1, 10'h013, 32'hFFFF_FFFF);
        check("R11 window write", rd, 32'h0);
        read_win("R9 gcfg kept", 32'h8040_0000);
        access(1'b0, 10'h012, 32'h0);
        check("R9 index kept", rd, 32'h23);

        access(1'b1, 10'h014, 32'h5);
        access(1'b0, 10'h012, 32'h0);
        check("R10 index kept", rd, 32'h23);
        access(1'b0, 10'h011, 32'h0);
        check("R10 unmapped read", rd, 32'h0);
        model_idx = 32'h23;

        void'($urandom(32'd1234));
        for (int n = 0; n < 300; n++) begin
            logic [2:0]  op  = 3'($urandom_range(0, 4));
            logic [31:0] v   = ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 40));
            logic [9:0]  oth = 10'($urandom_range(0, 1023));
            if (oth == 10'h012 || oth == 10'h013) oth = 10'h000;
            case (op)
                3'd0: begin access(1'b1, 10'h012, v); model_idx = v; end
                3'd1: begin access(1'b0, 10'h013, 0); check("R8 random window", rd, exp_window(model_idx)); end
                3'd2: begin access(1'b1, 10'h013, v); check("R9 random write", rd, 32'h0); end
                3'd3: begin access(1'b0, oth, 0); check("R10 random", rd, 32'h0); end
                default: begin access(1'b0, 10'h012, 0); check("R3 random", rd, model_idx); end
            endcase
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule